// File: doc/BRIEF.md
# SPI Master Shifter with Run-Time Mode and Frame Length

This block is a single-slave SPI master that runs one full-duplex frame for each accepted start strobe. Each frame shifts a word out on MOSI while it shifts a word in from MISO. The host chooses the clock polarity, the clock phase, a frame length of 4 to 16 bits and an SCK divider for each frame. The host presents these with a start strobe. The block then raises busy, selects the slave, and generates exactly one SCK cycle for each frame bit. At the end it deselects the slave and pulses done with the received word.

A frame-size code `c` selects a frame of `c+1` bits. Codes 0, 1 and 2 are clamped to a 4-bit frame. Only the low `N` bits of the transmit word take part, and they are sent most significant first, starting with bit `N-1`. The `N` received bits are placed right-justified in the receive word, and every bit above them reads zero. The SCK half-period is `div+1` system clocks. Chip select falls one half-period before the first SCK edge and rises one half-period after the last edge.

Top module: `spi_mode_master`

## Requirements
- R1: After reset, cs_n_o is 1, sck_o is 0 (mode 0 idle level), busy_o is 0, done_o is 0 and rx_word_o is 0.
- R2: A frame of N bits sends tx_word_i[N-1:0] on MOSI, most significant bit first, and at the same time collects N MISO bits. rx_word_o then holds them in bits [N-1:0], first received bit highest, with all upper bits zero.
- R3: While chip select is high, SCK stays at the polarity latched at the last accepted start (0 = rests low, 1 = rests high). It never moves while deselected.
- R4: With phase 0, MOSI holds bit N-1 from the moment chip select falls. Data is captured on every leading (idle-to-active) SCK edge, and MOSI advances on every trailing edge.
- R5: With phase 1, MOSI advances on every leading SCK edge, the first of which presents bit N-1. Data is captured on every trailing edge.
- R6: A frame-size code c in 3..15 gives N = c+1 bits, and codes 0..2 give N = 4. A frame produces exactly N SCK cycles.
- R7: Successive SCK edges are div+1 system clocks apart. The first edge comes div+1 clocks after chip select falls, and chip select rises div+1 clocks after the last edge.
- R8: A start is accepted only while idle, and busy_o and a low chip select follow on the next clock. A start during a frame is ignored. Polarity, phase, frame size, divider and transmit word are all taken at acceptance, so later changes to them have no effect on the running frame.
- R9: done_o is high for exactly one clock, in the first clock that chip select is high again. busy_o is low in that same clock, and rx_word_o is already updated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, one clock |
| tx_word_i | input | 16 | Word to transmit (low N bits used) |
| cpol_i | input | 1 | Clock polarity for the next frame |
| cpha_i | input | 1 | Clock phase for the next frame |
| fsize_i | input | 4 | Frame-size code, N = code+1, minimum 4 |
| div_i | input | 8 | SCK half-period minus one, in system clocks |
| miso_i | input | 1 | Serial data from slave |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-clock end-of-frame pulse |
| rx_word_o | output | 16 | Received word, right-justified |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to slave |
| cs_n_o | output | 1 | Active-low slave select |

## Verification
The bench goes after each of the four polarity/phase pairings through a slave model that launches and captures on the edges the mode calls for. A master that captures on the wrong edge would return its received word shifted by one bit. A master that launches late with phase 0 would lose bit N-1. It also runs the shortest, longest and clamped frame sizes at a divider of zero, and counts SCK cycles and measures the select-to-edge gaps. An off-by-one bit counter would show up as an extra or missing cycle, and a lost half-period as a gap one clock short. It also issues a start, with every configuration input flipped, during a running frame. A design that did not latch or did not gate the start would corrupt the word in flight or launch a second frame.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_TAIL  = 2'd2
  } spim_state_e;

  // Frame length from a size code: code+1, clamped into [min_bits, max_bits].
  function automatic int unsigned spim_frame_len(input int unsigned code,
                                                 input int unsigned min_bits,
                                                 input int unsigned max_bits);
    int unsigned n;
    n = code + 1;
    if (n < min_bits) n = min_bits;
    if (n > max_bits) n = max_bits;
    return n;
  endfunction

endpackage

// File: rtl/spim_tick_gen.sv
module spim_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end = (cnt_q == div_q);
  assign tick_o = run_i && at_end;

  always_comb begin
    div_d = div_q;
    if (load_i) div_d = div_i;
    if (!run_i || at_end) cnt_d = '0;
    else                  cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  a_r7_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_q);

  a_r7_idle_counter_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/spim_sequencer.sv
module spim_sequencer
  import spim_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CODE_W   = 4,
  parameter int MIN_BITS = 4,
  parameter int BIT_W    = $clog2(DATA_W + 1),
  parameter int EDGE_W   = $clog2(2 * DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [CODE_W-1:0] fsize_i,
  input  logic              tick_i,
  output logic              accept_o,
  output logic [BIT_W-1:0]  nbits_start_o,
  output logic [BIT_W-1:0]  nbits_o,
  output logic              launch_o,
  output logic              sample_o,
  output logic              finish_o,
  output logic              busy_o,
  output logic              cs_n_o,
  output logic              sck_o,
  output logic              done_o
);

  spim_state_e       state_q, state_d;
  logic [EDGE_W-1:0] idx_q, idx_d;
  logic [BIT_W-1:0]  nbits_q, nbits_d;
  logic              cpol_q, cpol_d;
  logic              cpha_q, cpha_d;
  logic              sck_q, sck_d;
  logic              cs_n_q, cs_n_d;
  logic              done_q, done_d;
  logic [BIT_W-1:0]  nbits_m1;
  logic [EDGE_W-1:0] last_idx;
  logic              edge_p;

  assign nbits_start_o = BIT_W'(spim_frame_len(32'(fsize_i), MIN_BITS, DATA_W));
  assign nbits_m1      = nbits_q - BIT_W'(1);
  // Edge indices run 0 .. 2N-1; the last one is odd.
  assign last_idx      = {nbits_m1[EDGE_W-2:0], 1'b1};

  assign accept_o = (state_q == SEQ_IDLE) && start_i;
  assign edge_p   = (state_q == SEQ_SHIFT) && tick_i;
  // Even index = leading edge. Phase 0 captures on leading, phase 1 on trailing.
  assign sample_o = edge_p && (idx_q[0] == cpha_q);
  assign launch_o = edge_p && (idx_q[0] != cpha_q);
  assign finish_o = (state_q == SEQ_TAIL) && tick_i;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    nbits_d = nbits_q;
    cpol_d  = cpol_q;
    cpha_d  = cpha_q;
    sck_d   = sck_q;
    cs_n_d  = cs_n_q;
    done_d  = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (start_i) begin
          state_d = SEQ_SHIFT;
          idx_d   = '0;
          nbits_d = nbits_start_o;
          cpol_d  = cpol_i;
          cpha_d  = cpha_i;
          sck_d   = cpol_i;
          cs_n_d  = 1'b0;
        end
      end
      SEQ_SHIFT: begin
        if (tick_i) begin
          sck_d = ~sck_q;
          if (idx_q == last_idx) state_d = SEQ_TAIL;
          else                   idx_d   = idx_q + EDGE_W'(1);
        end
      end
      SEQ_TAIL: begin
        if (tick_i) begin
          state_d = SEQ_IDLE;
          cs_n_d  = 1'b1;
          done_d  = 1'b1;
        end
      end
      default: begin
        state_d = SEQ_IDLE;
        cs_n_d  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      nbits_q <= BIT_W'(8);
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      nbits_q <= nbits_d;
      cpol_q  <= cpol_d;
      cpha_q  <= cpha_d;
      sck_q   <= sck_d;
      cs_n_q  <= cs_n_d;
      done_q  <= done_d;
    end
  end

  assign nbits_o = nbits_q;
  assign busy_o  = (state_q != SEQ_IDLE);
  assign cs_n_o  = cs_n_q;
  assign sck_o   = sck_q;
  assign done_o  = done_q;

  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE) |-> (sck_q == cpol_q));

  a_r6_edge_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_SHIFT) |-> (idx_q <= last_idx));

  a_r8_config_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != SEQ_IDLE) && ($past(state_q) != SEQ_IDLE)
      |-> $stable(nbits_q) && $stable(cpol_q) && $stable(cpha_q));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  a_r9_done_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> cs_n_q && (state_q == SEQ_IDLE));

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int DATA_W = 16,
  parameter int BIT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              cpha_i,
  input  logic [BIT_W-1:0]  nbits_start_i,
  input  logic [BIT_W-1:0]  nbits_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic              launch_i,
  input  logic              sample_i,
  input  logic              finish_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [DATA_W-1:0] rx_word_o
);

  logic [DATA_W-1:0] tx_sr_q, tx_sr_d;
  logic [DATA_W-1:0] rx_sr_q, rx_sr_d;
  logic [DATA_W-1:0] rx_word_q, rx_word_d;
  logic              mosi_q, mosi_d;
  logic [BIT_W-1:0]  pad;
  logic [DATA_W-1:0] aligned;

  // Move bit N-1 of the transmit word to the top of the shift register.
  assign pad     = BIT_W'(DATA_W) - nbits_start_i;
  assign aligned = tx_word_i << pad;

  always_comb begin
    tx_sr_d   = tx_sr_q;
    rx_sr_d   = rx_sr_q;
    rx_word_d = rx_word_q;
    mosi_d    = mosi_q;
    if (accept_i) begin
      rx_sr_d = '0;
      if (!cpha_i) begin
        mosi_d  = aligned[DATA_W-1];
        tx_sr_d = aligned << 1;
      end else begin
        mosi_d  = 1'b0;
        tx_sr_d = aligned;
      end
    end else begin
      if (launch_i) begin
        mosi_d  = tx_sr_q[DATA_W-1];
        tx_sr_d = tx_sr_q << 1;
      end
      if (sample_i) rx_sr_d = {rx_sr_q[DATA_W-2:0], miso_i};
      if (finish_i) rx_word_d = rx_sr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr_q   <= '0;
      rx_sr_q   <= '0;
      rx_word_q <= '0;
      mosi_q    <= 1'b0;
    end else begin
      tx_sr_q   <= tx_sr_d;
      rx_sr_q   <= rx_sr_d;
      rx_word_q <= rx_word_d;
      mosi_q    <= mosi_d;
    end
  end

  assign mosi_o    = mosi_q;
  assign rx_word_o = rx_word_q;

  a_r2_rx_right_justified: assert property (@(posedge clk) disable iff (!rst_n)
    finish_i |-> ((rx_sr_q >> nbits_i) == '0));

  a_r2_rx_word_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(finish_i) && !finish_i |=> $stable(rx_word_q));

endmodule

// File: rtl/spi_mode_master.sv
module spi_mode_master #(
  parameter int DATA_W   = 16,
  parameter int CODE_W   = 4,
  parameter int DIV_W    = 8,
  parameter int MIN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic [CODE_W-1:0] fsize_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_word_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              cs_n_o
);

  localparam int BIT_W  = $clog2(DATA_W + 1);
  localparam int EDGE_W = $clog2(2 * DATA_W);

  logic             accept;
  logic             tick;
  logic             launch;
  logic             sample;
  logic             finish;
  logic [BIT_W-1:0] nbits_start;
  logic [BIT_W-1:0] nbits;

  spim_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .div_i  (div_i),
    .run_i  (busy_o),
    .tick_o (tick)
  );

  spim_sequencer #(
    .DATA_W   (DATA_W),
    .CODE_W   (CODE_W),
    .MIN_BITS (MIN_BITS),
    .BIT_W    (BIT_W),
    .EDGE_W   (EDGE_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .cpol_i        (cpol_i),
    .cpha_i        (cpha_i),
    .fsize_i       (fsize_i),
    .tick_i        (tick),
    .accept_o      (accept),
    .nbits_start_o (nbits_start),
    .nbits_o       (nbits),
    .launch_o      (launch),
    .sample_o      (sample),
    .finish_o      (finish),
    .busy_o        (busy_o),
    .cs_n_o        (cs_n_o),
    .sck_o         (sck_o),
    .done_o        (done_o)
  );

  spim_shifter #(
    .DATA_W (DATA_W),
    .BIT_W  (BIT_W)
  ) u_shift (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept_i      (accept),
    .cpha_i        (cpha_i),
    .nbits_start_i (nbits_start),
    .nbits_i       (nbits),
    .tx_word_i     (tx_word_i),
    .launch_i      (launch),
    .sample_i      (sample),
    .finish_i      (finish),
    .miso_i        (miso_i),
    .mosi_o        (mosi_o),
    .rx_word_o     (rx_word_o)
  );

  a_r3_sck_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o && $past(cs_n_o) |-> $stable(sck_o));

  a_r8_select_tracks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> busy_o);

  a_r7_no_edge_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o && $past(!cs_n_o) && !$stable(sck_o) |-> $past(tick));

endmodule

// File: tb/spi_mode_master_test.sv
module spi_mode_master_test;

  typedef struct packed {
    logic [15:0] rx;
    logic [15:0] tx;
    logic [4:0]  n;
    logic [7:0]  dv;
    logic        pol;
    logic        pha;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] tx_word;
  logic        cpol, cpha;
  logic [3:0]  fsize;
  logic [7:0]  div;
  logic        miso;
  logic        busy, done, sck, mosi, cs_n;
  logic [15:0] rx_word;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  exp_t exp_q[$];

  // slave model state
  logic [15:0] s_tx;
  logic        s_cpol, s_cpha;
  int          s_n, s_div, s_bit;
  logic [15:0] s_cap;
  int cyc, t_fall, t_first, t_last, t_rise, lead_cnt;
  bit first_seen, half_bad;
  logic prev_sck, prev_cs, prev_done;

  always #10 clk = ~clk;

  spi_mode_master uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .tx_word_i (tx_word),
    .cpol_i    (cpol),
    .cpha_i    (cpha),
    .fsize_i   (fsize),
    .div_i     (div),
    .miso_i    (miso),
    .busy_o    (busy),
    .done_o    (done),
    .rx_word_o (rx_word),
    .sck_o     (sck),
    .mosi_o    (mosi),
    .cs_n_o    (cs_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // Slave model and monitor, evaluated away from the active edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_sck  = sck;
      prev_cs   = cs_n;
      prev_done = done;
    end else begin
      cyc++;
      if (prev_cs && !cs_n) begin
        t_fall = cyc; first_seen = 0; lead_cnt = 0; s_cap = '0; half_bad = 0;
        s_bit = s_n - 1;
        if (!s_cpha) miso = s_tx[s_bit];
      end else if (!cs_n && (sck != prev_sck)) begin
        bit lead;
        lead = (sck != s_cpol);
        if (first_seen && ((cyc - t_last) != s_div + 1)) half_bad = 1;
        if (!first_seen) begin first_seen = 1; t_first = cyc; end
        t_last = cyc;
        if (lead) lead_cnt++;
        if (lead ^ s_cpha) begin
          s_cap = {s_cap[14:0], mosi};
        end else if (s_cpha) begin
          if (s_bit >= 0) miso = s_tx[s_bit];
          s_bit--;
        end else begin
          s_bit--;
          if (s_bit >= 0) miso = s_tx[s_bit];
        end
      end else if (cs_n && (sck != prev_sck)) begin
        chk(0, "R3", "sck moved while deselected", 32'(sck), 32'(prev_sck));
      end
      if (!prev_cs && cs_n) t_rise = cyc;
      if (prev_done && done) chk(0, "R9", "done longer than one clock", 1, 0);
      if (done) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8", "done without an accepted start", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(rx_word == e.rx, "R2", "received word", 32'(rx_word), 32'(e.rx));
          if (e.pha) chk(s_cap == e.tx, "R5", "bits seen by slave", 32'(s_cap), 32'(e.tx));
          else       chk(s_cap == e.tx, "R4", "bits seen by slave", 32'(s_cap), 32'(e.tx));
          chk(lead_cnt == int'(e.n), "R6", "sck cycles", 32'(lead_cnt), 32'(e.n));
          chk((t_first - t_fall) == int'(e.dv) + 1, "R7", "select to first edge",
              32'(t_first - t_fall), 32'(int'(e.dv) + 1));
          chk((t_rise - t_last) == int'(e.dv) + 1, "R7", "last edge to deselect",
              32'(t_rise - t_last), 32'(int'(e.dv) + 1));
          chk(!half_bad, "R7", "half period", 32'(half_bad), 0);
          chk(sck == e.pol, "R3", "idle level", 32'(sck), 32'(e.pol));
          chk(!busy && cs_n, "R9", "busy/select at done", 32'({busy, cs_n}), 32'h1);
        end
      end
      prev_sck  = sck;
      prev_cs   = cs_n;
      prev_done = done;
    end
  end

  // Driver: pushes the expected result, then starts the frame.
  task automatic xfer(input logic [15:0] tx, input logic [15:0] srx,
                      input logic pol, input logic pha,
                      input logic [3:0] code, input logic [7:0] dv, input bit poke);
    int n;
    logic [15:0] m;
    exp_t e;
    n = (code < 4'd3) ? 4 : int'(code) + 1;
    m = (n == 16) ? 16'hFFFF : 16'((32'h1 << n) - 1);
    while (busy) @(negedge clk);
    @(negedge clk);
    s_tx = srx; s_cpol = pol; s_cpha = pha; s_n = n; s_div = int'(dv);
    e.rx = srx & m; e.tx = tx & m; e.n = 5'(n); e.dv = dv; e.pol = pol; e.pha = pha;
    exp_q.push_back(e);
    tx_word = tx; cpol = pol; cpha = pha; fsize = code; div = dv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !cs_n, "R8", "busy and select after start", 32'({busy, cs_n}), 32'h2);
    if (poke) begin
      repeat (3) @(negedge clk);
      tx_word = ~tx; cpol = ~pol; cpha = ~pha; fsize = 4'd5; div = 8'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    if (poke) begin
      repeat (4) @(negedge clk);
      chk(!busy && cs_n, "R8", "ignored start began a frame", 32'({busy, cs_n}), 32'h1);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; tx_word = '0; cpol = 1'b0; cpha = 1'b0;
    fsize = 4'd7; div = 8'd1; miso = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1", "reset cs_n", 32'(cs_n), 1);
    chk(sck == 1'b0, "R1", "reset sck", 32'(sck), 0);
    chk(!busy && !done, "R1", "reset busy/done", 32'({busy, done}), 0);
    chk(rx_word == 16'h0, "R1", "reset rx word", 32'(rx_word), 0);

    xfer(16'h00A5, 16'h003C, 1'b0, 1'b0, 4'd7,  8'd1, 0);  // mode 0, 8 bits
    xfer(16'hBEEF, 16'h1234, 1'b0, 1'b1, 4'd15, 8'd0, 0);  // mode 1, 16 bits, fastest
    xfer(16'h000B, 16'h0006, 1'b1, 1'b0, 4'd3,  8'd2, 0);  // mode 2, 4 bits
    xfer(16'h0ACE, 16'h0F0F, 1'b1, 1'b1, 4'd11, 8'd3, 0);  // mode 3, 12 bits
    xfer(16'hFFF7, 16'hABCD, 1'b0, 1'b0, 4'd0,  8'd0, 0);  // R6 clamp to 4 bits
    xfer(16'h8001, 16'h8001, 1'b1, 1'b1, 4'd15, 8'd0, 0);  // 16 bits, edge bits
    xfer(16'h02D3, 16'h0155, 1'b0, 1'b1, 4'd9,  8'd2, 1);  // R8 start during frame
    for (int i = 0; i < 8; i++) begin
      xfer(16'(16'h1357 * (i + 1)), 16'(16'hA5A5 ^ (i * 16'h0F0F)),
           1'((i >> 1) & 1), 1'(i & 1), 4'(3 + i), 8'(i % 3), 0);
    end
    repeat (5) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule